// File: doc/BRIEF.md
# Masked Alarm Match Controller

This block decides when a clock/calendar alarm fires. Six alarm bytes (seconds, minutes, hours, date, month, day of week) each carry a compare value and a per-field enable. When the time counters advance on a one-second tick, every enabled field is compared against the running time. A qualifying match sets a sticky alarm flag and drives a shared active-low interrupt pin. The pin is either held low until software clears the flag or pulsed low for a fixed window.

The time counters and the frequency divider lie outside this block and reach it as inputs. Bus decoding is also outside. The block sees byte write strobes with an address, plus two strobes that mark the start and the completed end of a status-register read. The block also covers these cases:
- an optional auto-clear of the status flags when a status read completes;
- a battery-backup condition that can silence the pin;
- a frequency-output selection that overrides the alarm and takes over the pin.

Top module: `alarm_match_ctrl`

## Requirements
- R1: Addresses 0 to 5 hold the alarm bytes for seconds, minutes, hours, date, month and day of week, in that order. In each byte, bit 7 enables the field and bits 6:0 hold the compare value. `time_flat` carries the same fields in the same order, 7 bits each, with field i at bits [7*i+6:7*i].
- R2: A match exists when at least one field is enabled and every enabled field equals its time field. It is evaluated only in a cycle with `sec_tick` high. The alarm flag is set at the clock edge that samples that tick. With no field enabled the alarm never fires.
- R3: The control byte is at address 6. Its bit 0 is the master alarm enable. When bit 0 is 0, no match sets the flag or moves the pin.
- R4: Single mode is control bit 1 = 0. In this mode `irq_n` is low for exactly as long as the alarm flag is set.
- R5: Recurring mode is control bit 1 = 1. A match sets the flag and drives `irq_n` low for exactly PULSE_TICKS pulses of `tick_32k`, counted from the edge after the match edge. The default PULSE_TICKS of 8192 at 32.768 kHz gives 250 ms.
- R6: The status byte is at address 8. Bit 0 is the alarm flag and bit 1 is the battery flag, and both are visible on `alarm_flag` and `batt_flag`. Writing 0 to a bit clears that flag. Writing 1 has no effect.
- R7: The battery flag is set in every cycle in which `on_battery` is high.
- R8: Auto-clear is control bit 2. With it set, a `stat_rd_done` pulse clears every flag that was not set after the most recent `stat_rd_start`. A flag set during the read stays set. With bit 2 clear, reads leave the flags unchanged.
- R9: The frequency select is bits 3:0 of address 7. When it is nonzero, the alarm flag cannot be set and `irq_n` follows `fout_clk`.
- R10: Control bit 3 is the battery-mode pin disable. While it is set and `on_battery` is high, `irq_n` is held high.
- R11: After reset all registers and flags are 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz for the pulse timer |
| sec_tick | input | 1 | One-cycle pulse when the time fields update |
| time_flat | input | NF*(FW-1) | Current time fields, 7 bits each, seconds at the LSB end |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | FW | Register write data |
| stat_rd_start | input | 1 | Status read has begun |
| stat_rd_done | input | 1 | Status read has ended with a stop |
| on_battery | input | 1 | Running from backup supply |
| fout_clk | input | 1 | Selected divider output for frequency mode |
| irq_n | output | 1 | Shared active-low interrupt / frequency pin |
| alarm_flag | output | 1 | Sticky alarm flag |
| batt_flag | output | 1 | Sticky battery flag |

## Verification
The hardest case to reach is a match that lands inside a status read while auto-clear is on. The flag must survive the read that spans it, yet an older flag must be cleared by the same read. The bench reaches this by issuing the read-start strobe, then a one-second tick with a matching time, then the read-done strobe, and it checks that the flag is still set. It also runs the opposite order, so that the flag is set before the read and is cleared by it. The recurring-pulse length is checked by counting low cycles with the tick held active, which gives an exact cycle count.

// File: rtl/alarm_pkg.sv
// Shared constants and types for the masked alarm match controller.
// Assumes byte-wide registers and a flat address space below 16.
package alarm_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int FIELD_BITS = 8;
    localparam int ADDR_BITS  = 4;
    localparam int FSEL_BITS  = 4;

    localparam int ADDR_CTRL = 6;
    localparam int ADDR_FSEL = 7;
    localparam int ADDR_STAT = 8;

    // Control byte layout, bits 3:0 (MSB first in the struct).
    typedef struct packed {
        logic batt_off;    // bit 3
        logic auto_clr;    // bit 2
        logic pulse_mode;  // bit 1
        logic master_en;   // bit 0
    } ctrl_t;
endpackage

// File: rtl/alarm_regfile.sv
// Holds the alarm bytes, the control byte and the frequency select.
// Assumes one write per cycle; the status byte is handled elsewhere.
module alarm_regfile
    import alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int FW = FIELD_BITS,
    parameter int AW = ADDR_BITS,
    parameter int SW = FSEL_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [FW-1:0] wr_data,
    output logic [NF*FW-1:0] alarm_bytes,
    output ctrl_t         ctrl,
    output logic [SW-1:0] fsel
);
    genvar i;
    generate
        for (i = 0; i < NF; i++) begin : g_alarm
            // Store one alarm byte at address i.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alarm_bytes[i*FW +: FW] <= '0;
                else if (wr_en && wr_addr == AW'(i))
                    alarm_bytes[i*FW +: FW] <= wr_data;
            end
        end
    endgenerate

    // Store the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && wr_addr == AW'(ADDR_CTRL))
            ctrl <= ctrl_t'(wr_data[3:0]);
    end

    // Store the frequency select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fsel <= '0;
        else if (wr_en && wr_addr == AW'(ADDR_FSEL))
            fsel <= wr_data[SW-1:0];
    end
endmodule

// File: rtl/alarm_comparator.sv
// Compares each enabled alarm field with its time field.
// Assumes the enable sits in the top bit of each alarm byte; purely combinational.
module alarm_comparator #(
    parameter int NF = 6,
    parameter int FW = 8,
    localparam int VW = FW - 1
) (
    input  logic [NF*FW-1:0] alarm_bytes,
    input  logic [NF*VW-1:0] time_flat,
    output logic             hit
);
    logic [NF-1:0] field_en;
    logic [NF-1:0] field_ok;

    genvar i;
    generate
        for (i = 0; i < NF; i++) begin : g_field
            assign field_en[i] = alarm_bytes[i*FW + VW];
            assign field_ok[i] = !field_en[i] ||
                                 (alarm_bytes[i*FW +: VW] == time_flat[i*VW +: VW]);
        end
    endgenerate

    // A match needs at least one enabled field and agreement on all enabled ones.
    always_comb hit = (&field_ok) && (|field_en);
endmodule

// File: rtl/alarm_pulse_timer.sv
// Times the recurring-mode low pulse in ticks of the slow enable.
// Assumes a start reloads the full window even if a pulse is running.
module alarm_pulse_timer #(
    parameter int TICKS = 8192,
    localparam int CW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active
);
    logic [CW-1:0] cnt_q;

    // Load on start, count down on each tick while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(TICKS);
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb active = (cnt_q != '0);
endmodule

// File: rtl/alarm_status_flags.sv
// Sticky alarm and battery flags with write-0 clear and read auto-clear.
// Assumes a read-start strobe precedes the matching read-done strobe.
module alarm_status_flags #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_v,
    input  logic             stat_wr,
    input  logic [NFLAG-1:0] wr_bits,
    input  logic             rd_start,
    input  logic             rd_done,
    input  logic             auto_clr,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] fresh_q;

    // Update each flag: a set wins, then a write of 0, then a read auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            fresh_q <= '0;
        end else begin
            for (int b = 0; b < NFLAG; b++) begin
                if (set_v[b])
                    flags[b] <= 1'b1;
                else if (stat_wr && !wr_bits[b])
                    flags[b] <= 1'b0;
                else if (rd_done && auto_clr && !fresh_q[b])
                    flags[b] <= 1'b0;

                if (rd_start)
                    fresh_q[b] <= 1'b0;
                else if (set_v[b])
                    fresh_q[b] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/alarm_match_ctrl.sv
// Top of the masked alarm match controller: registers, field compare,
// sticky flags, pulse timer and the shared interrupt pin multiplexer.
// Assumes time fields are stable in the cycle where sec_tick is high.
module alarm_match_ctrl
    import alarm_pkg::*;
#(
    parameter int NF          = NUM_FIELDS,
    parameter int FW          = FIELD_BITS,
    parameter int AW          = ADDR_BITS,
    parameter int SW          = FSEL_BITS,
    parameter int PULSE_TICKS = 8192,
    localparam int VW = FW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_32k,
    input  logic             sec_tick,
    input  logic [NF*VW-1:0] time_flat,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [FW-1:0]    wr_data,
    input  logic             stat_rd_start,
    input  logic             stat_rd_done,
    input  logic             on_battery,
    input  logic             fout_clk,
    output logic             irq_n,
    output logic             alarm_flag,
    output logic             batt_flag
);
    logic [NF*FW-1:0] alarm_bytes;
    ctrl_t            ctrl_q;
    logic [SW-1:0]    fsel;
    logic             alarm_hit;
    logic             alarm_qual;
    logic             pulse_active;
    logic             stat_wr;
    logic [1:0]       flags;

    alarm_regfile #(.NF(NF), .FW(FW), .AW(AW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alarm_bytes(alarm_bytes), .ctrl(ctrl_q), .fsel(fsel)
    );

    alarm_comparator #(.NF(NF), .FW(FW)) u_cmp (
        .alarm_bytes(alarm_bytes), .time_flat(time_flat), .hit(alarm_hit)
    );

    // A match counts only on the update tick, when enabled and not overridden.
    always_comb alarm_qual = sec_tick && ctrl_q.master_en && (fsel == '0) && alarm_hit;

    always_comb stat_wr = wr_en && (wr_addr == AW'(ADDR_STAT));

    alarm_status_flags #(.NFLAG(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_v({on_battery, alarm_qual}),
        .stat_wr(stat_wr), .wr_bits(wr_data[1:0]), .rd_start(stat_rd_start),
        .rd_done(stat_rd_done), .auto_clr(ctrl_q.auto_clr), .flags(flags)
    );

    alarm_pulse_timer #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(alarm_qual && ctrl_q.pulse_mode),
        .tick(tick_32k), .active(pulse_active)
    );

    always_comb begin
        alarm_flag = flags[0];
        batt_flag  = flags[1];
    end

    // Pin priority: battery disable, then frequency output, then alarm mode.
    always_comb begin
        if (on_battery && ctrl_q.batt_off)
            irq_n = 1'b1;
        else if (fsel != '0)
            irq_n = fout_clk;
        else if (ctrl_q.pulse_mode)
            irq_n = !pulse_active;
        else
            irq_n = !alarm_flag;
    end
endmodule

// File: rtl/alarm_match_ctrl_chk.sv
// Property checker for alarm_match_ctrl, attached by bind below.
// Assumes the top's internal ctrl_q, fsel and alarm_hit names.
module alarm_match_ctrl_chk #(
    parameter int AW = 4,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic          alarm_hit,
    input logic          master_en,
    input logic          batt_off,
    input logic [SW-1:0] fsel,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          wr_lsb,
    input logic          stat_rd_done,
    input logic          on_battery,
    input logic          alarm_flag,
    input logic          irq_n
);
    logic clr_wr;
    always_comb clr_wr = wr_en && (wr_addr == AW'(alarm_pkg::ADDR_STAT)) && !wr_lsb;

    // R2: a qualified match sets the flag on the next cycle.
    assert_match_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && alarm_hit && master_en && fsel == '0) |=> alarm_flag);

    // R3: with the master enable off the flag does not change from a tick.
    assert_master_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !master_en && !clr_wr && !stat_rd_done) |=> $stable(alarm_flag));

    // R6: writing 1 to the flag bit never sets it.
    assert_write_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(alarm_pkg::ADDR_STAT) && wr_lsb && !alarm_flag && !sec_tick)
        |=> !alarm_flag);

    // R6: the flag stays set unless cleared by a write of 0 or a completed read.
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_wr && !stat_rd_done) |=> alarm_flag);

    // R9: a nonzero frequency select keeps a clear flag clear across a tick.
    assert_fsel_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && fsel != '0 && !alarm_flag) |=> !alarm_flag);

    // R10: the pin is released while on backup with the disable bit set.
    assert_batt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && batt_off) |-> irq_n);
endmodule

bind alarm_match_ctrl alarm_match_ctrl_chk #(.AW(AW), .SW(SW)) chk_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .alarm_hit(alarm_hit),
    .master_en(ctrl_q.master_en), .batt_off(ctrl_q.batt_off), .fsel(fsel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lsb(wr_data[0]),
    .stat_rd_done(stat_rd_done), .on_battery(on_battery),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
);

// File: tb/alarm_match_ctrl_tb_top.sv
// Self-checking bench: a vector table for field matching, then directed tests.
module alarm_match_ctrl_tb_top;
    localparam int NF = 6;
    localparam int FW = 8;
    localparam int VW = 7;
    localparam int PT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_32k = 1'b1;
    logic sec_tick = 1'b0;
    logic [NF*VW-1:0] time_flat = '0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic stat_rd_start = 1'b0;
    logic stat_rd_done = 1'b0;
    logic on_battery = 1'b0;
    logic fout_clk = 1'b0;
    logic irq_n, alarm_flag, batt_flag;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    alarm_match_ctrl #(.PULSE_TICKS(PT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .sec_tick(sec_tick),
        .time_flat(time_flat), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stat_rd_start(stat_rd_start), .stat_rd_done(stat_rd_done),
        .on_battery(on_battery), .fout_clk(fout_clk), .irq_n(irq_n),
        .alarm_flag(alarm_flag), .batt_flag(batt_flag)
    );

    typedef struct packed {
        logic [5:0][7:0] alm;  // [0]=seconds ... [5]=day of week
        logic [5:0][7:0] tm;
        logic            exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{48'h00_00_00_00_00_B0, 48'h03_05_21_17_42_30, 1'b1}, // seconds only, equal
        '{48'h00_00_00_00_00_B0, 48'h03_05_21_17_42_31, 1'b0}, // seconds only, differ
        '{48'h83_85_A1_97_C2_B0, 48'h03_05_21_17_42_30, 1'b1}, // all fields equal
        '{48'h83_85_A1_97_C2_B0, 48'h03_06_21_17_42_30, 1'b0}, // month differs
        '{48'h03_05_21_17_42_30, 48'h03_05_21_17_42_30, 1'b0}, // nothing enabled
        '{48'h83_00_00_97_00_00, 48'h03_05_21_17_59_07, 1'b1}  // hour and weekday
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [5:0][7:0] t);
        for (int i = 0; i < NF; i++) time_flat[i*VW +: VW] = t[i][6:0];
    endtask

    task automatic load_alarm(input logic [5:0][7:0] a);
        for (int i = 0; i < NF; i++) wr(4'(i), a[i]);
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic rd_start();
        @(negedge clk); stat_rd_start = 1'b1;
        @(negedge clk); stat_rd_start = 1'b0;
    endtask

    task automatic rd_done();
        @(negedge clk); stat_rd_done = 1'b1;
        @(negedge clk); stat_rd_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 flag after reset", alarm_flag, 0);
        check("R11 batt after reset", batt_flag, 0);
        check("R11 pin after reset", irq_n, 1);

        // R1 R2 R4: table of field patterns in single mode.
        wr(4'd6, 8'h01);
        foreach (VECS[k]) begin
            load_alarm(VECS[k].alm);
            set_time(VECS[k].tm);
            wr(4'd8, 8'h00);
            tick();
            check($sformatf("R2 vector %0d flag", k), alarm_flag, VECS[k].exp);
            check($sformatf("R4 vector %0d pin", k), irq_n, !VECS[k].exp);
        end
        check("R1 vector table walked", 1, 1);

        // R3: master enable off.
        load_alarm(VECS[0].alm);
        set_time(VECS[0].tm);
        wr(4'd8, 8'h00);
        wr(4'd6, 8'h00);
        tick();
        check("R3 flag with master off", alarm_flag, 0);
        check("R3 pin with master off", irq_n, 1);

        // R6: write 1 leaves flag, write 0 clears.
        wr(4'd6, 8'h01);
        tick();
        wr(4'd8, 8'h03);
        check("R6 write one keeps flag", alarm_flag, 1);
        wr(4'd8, 8'h00);
        check("R6 write zero clears flag", alarm_flag, 0);
        check("R4 pin released after clear", irq_n, 1);

        // R5: recurring pulse length.
        wr(4'd6, 8'h03);
        tick();
        check("R5 flag set in recurring mode", alarm_flag, 1);
        begin
            int lows = 0;
            for (int c = 0; c < 40; c++) begin
                if (!irq_n) lows++;
                @(negedge clk);
            end
            check("R5 pulse low cycles", lows, PT);
        end
        check("R5 pin high while flag still set", irq_n, 1);

        // R8: auto-clear on a completed read.
        wr(4'd8, 8'h00);
        wr(4'd6, 8'h05);
        tick();
        rd_start();
        rd_done();
        check("R8 flag cleared by read", alarm_flag, 0);
        rd_start();
        tick();
        rd_done();
        check("R8 flag set during read survives", alarm_flag, 1);

        // R7 R8: battery flag set and auto-cleared.
        @(negedge clk); on_battery = 1'b1;
        @(negedge clk); on_battery = 1'b0;
        check("R7 battery flag set", batt_flag, 1);
        rd_start();
        rd_done();
        check("R8 battery flag cleared by read", batt_flag, 0);

        // R8: no auto-clear when the bit is off.
        wr(4'd6, 8'h01);
        tick();
        rd_start();
        rd_done();
        check("R8 read without auto-clear keeps flag", alarm_flag, 1);

        // R9: frequency select blocks the alarm and drives the pin.
        wr(4'd8, 8'h00);
        wr(4'd7, 8'h01);
        tick();
        check("R9 flag blocked by frequency select", alarm_flag, 0);
        @(negedge clk); fout_clk = 1'b0; #1;
        check("R9 pin follows fout low", irq_n, 0);
        fout_clk = 1'b1; #1;
        check("R9 pin follows fout high", irq_n, 1);
        wr(4'd7, 8'h00);

        // R10: battery disable releases the pin.
        wr(4'd6, 8'h09);
        tick();
        check("R10 flag set before backup", alarm_flag, 1);
        check("R10 pin low on main supply", irq_n, 0);
        @(negedge clk); on_battery = 1'b1; #1;
        check("R10 pin released on backup", irq_n, 1);
        @(negedge clk); on_battery = 1'b0; #1;
        check("R10 pin low again on main supply", irq_n, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule